// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is an up-counter of parameterised width (four bits by default) that advances on the rising clock edge. It can be forced to zero at any moment by an active-low asynchronous clear. It can also be preset from a data bus by an active-low synchronous load. Counting happens only when two separate enables are both high. The first is a parallel enable that stalls the counting alone. The second is a trickle enable that also qualifies the terminal-count flag.

Wider counters are built by chaining stages. Every stage shares the clock, the clear, the load and the parallel enable. The terminal-count flag of each stage feeds the trickle enable of the next. Because the flag is an AND of the trickle enable with the all-ones state, the carry looks ahead across the chain: all stages change state on the same edge.

Two parameters choose how the logic is built. One picks the incrementer: an adder, or a per-bit toggle network driven by a prefix AND. The other picks the terminal-count detector: a flat reduction, or a two-level tree of fixed-size groups. Both choices give the same behaviour at the ports.

Top module: `casc_bin_counter`

## Requirements
- R1: Every count bit takes its new value on the same rising edge of `clk`; between edges the count output holds still.
- R2: While `clr_n` is low the count is zero, with no clock edge needed, whatever the levels of `clk`, `ld_n`, `en_par` and `en_trk`.
- R3: When `ld_n` is low at a rising edge (and `clr_n` is high), the count becomes the value on `din`.
- R4: A load takes place whatever the levels of `en_par` and `en_trk`.
- R5: With `ld_n` high, the count rises by one at a rising edge only when `en_par` and `en_trk` are both high; otherwise it keeps its value.
- R6: `tc` is high exactly when `en_trk` is high and every count bit is 1. `en_par` has no effect on `tc`, and `tc` follows `en_trk` with no clock edge.
- R7: A count step from the all-ones value gives zero.
- R8: Two stages, with the upper stage's `en_trk` driven by the lower stage's `tc` and all other controls shared, behave as one counter of twice the width. The upper stage's `tc` is that wide counter's terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state |
| clr_n | input | 1 | Active-low asynchronous clear of the count |
| ld_n | input | 1 | Active-low synchronous load of `din` |
| en_par | input | 1 | Parallel count enable; gates counting only |
| en_trk | input | 1 | Trickle count enable; gates counting and `tc` |
| din | input | WIDTH | Preset value |
| cnt | output | WIDTH | Current count |
| tc | output | 1 | Terminal count: `en_trk` AND all count bits set |

## Verification
The embedded properties check the following on every clock edge: a load captures the data bus, the count holds or steps by exactly one according to the two enables, all-ones wraps to zero, the terminal flag stays low while the trickle enable is low, and the count is zero while the clear is held. Some behaviour only the bench scenarios can show. These are the clear taking effect in the middle of a cycle, before any edge, and the carry rippling correctly from the lower stage into the upper stage of a chained pair. The bench compares the pair against an 8-bit reference through loads, stalls on each enable, wrap-around and long runs. It also shows that the terminal flag of the pair ignores the parallel enable.

// File: rtl/casc_cnt_pkg.sv
`timescale 1ns/1ps
package casc_cnt_pkg;

   typedef enum logic [1:0] {
      CNT_OP_HOLD = 2'd0,
      CNT_OP_STEP = 2'd1,
      CNT_OP_LOAD = 2'd2
   } cnt_op_e;

   localparam int INC_ADDER  = 0;
   localparam int INC_TOGGLE = 1;

   localparam int TC_FLAT = 0;
   localparam int TC_TREE = 1;

   // Load outranks counting; counting needs both enables; otherwise hold.
   function automatic cnt_op_e choose_op(input logic ld_n,
                                         input logic en_par,
                                         input logic en_trk);
      if (!ld_n)
         return CNT_OP_LOAD;
      else if (en_par && en_trk)
         return CNT_OP_STEP;
      else
         return CNT_OP_HOLD;
   endfunction

endpackage

// File: rtl/casc_cnt_ctrl.sv
`timescale 1ns/1ps
module casc_cnt_ctrl
   import casc_cnt_pkg::*;
(
   input  logic    ld_n,
   input  logic    en_par,
   input  logic    en_trk,
   output cnt_op_e op
);

   always_comb begin
      op = choose_op(ld_n, en_par, en_trk);
   end

endmodule

// File: rtl/casc_cnt_next.sv
`timescale 1ns/1ps
module casc_cnt_next
   import casc_cnt_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter int INC_STYLE = INC_TOGGLE
)(
   input  cnt_op_e          op,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] inc;

   generate
      if (INC_STYLE == INC_ADDER) begin : g_inc_adder
         assign inc = cur + ONE;
      end else begin : g_inc_toggle
         // Bit i toggles when every lower bit is 1 (prefix AND chain).
         logic [WIDTH:0] low_ones;
         assign low_ones[0] = 1'b1;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign low_ones[i+1] = low_ones[i] & cur[i];
            assign inc[i]        = cur[i] ^ low_ones[i];
         end
      end
   endgenerate

   always_comb begin
      unique case (op)
         CNT_OP_LOAD: nxt = din;
         CNT_OP_STEP: nxt = inc;
         default:     nxt = cur;
      endcase
   end

endmodule

// File: rtl/casc_cnt_reg.sv
`timescale 1ns/1ps
module casc_cnt_reg #(
   parameter int WIDTH = 4
)(
   input  logic             clk,
   input  logic             clr_n,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)
         q <= '0;
      else
         q <= nxt;
   end

endmodule

// File: rtl/casc_cnt_tc.sv
`timescale 1ns/1ps
module casc_cnt_tc
   import casc_cnt_pkg::*;
#(
   parameter int WIDTH    = 4,
   parameter int TC_STYLE = TC_FLAT,
   parameter int TC_GROUP = 4
)(
   input  logic [WIDTH-1:0] cnt,
   input  logic             en_trk,
   output logic             tc
);

   localparam int NGRP  = (WIDTH + TC_GROUP - 1) / TC_GROUP;
   localparam int PADW  = NGRP * TC_GROUP;

   generate
      if (TC_STYLE == TC_FLAT) begin : g_flat
         assign tc = en_trk & (&cnt);
      end else begin : g_tree
         logic [PADW-1:0] padded;
         logic [NGRP-1:0] grp_full;
         always_comb begin
            padded            = '1;
            padded[WIDTH-1:0] = cnt;
         end
         for (genvar g = 0; g < NGRP; g++) begin : g_grp
            assign grp_full[g] = &padded[g*TC_GROUP +: TC_GROUP];
         end
         assign tc = en_trk & (&grp_full);
      end
   endgenerate

endmodule

// File: rtl/casc_bin_counter.sv
`timescale 1ns/1ps
module casc_bin_counter
   import casc_cnt_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter int INC_STYLE = INC_TOGGLE,
   parameter int TC_STYLE  = TC_TREE,
   parameter int TC_GROUP  = 2
)(
   input  logic             clk,
   input  logic             clr_n,
   input  logic             ld_n,
   input  logic             en_par,
   input  logic             en_trk,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] cnt,
   output logic             tc
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("casc_bin_counter: WIDTH must be at least 1");
      end
      if (INC_STYLE != INC_ADDER && INC_STYLE != INC_TOGGLE) begin : g_bad_inc
         $error("casc_bin_counter: unknown INC_STYLE");
      end
      if (TC_STYLE != TC_FLAT && TC_STYLE != TC_TREE) begin : g_bad_tc
         $error("casc_bin_counter: unknown TC_STYLE");
      end
      if (TC_GROUP < 1) begin : g_bad_grp
         $error("casc_bin_counter: TC_GROUP must be at least 1");
      end
   endgenerate

   cnt_op_e          op;
   logic [WIDTH-1:0] nxt;

   casc_cnt_ctrl u_ctrl (
      .ld_n   (ld_n),
      .en_par (en_par),
      .en_trk (en_trk),
      .op     (op)
   );

   casc_cnt_next #(
      .WIDTH     (WIDTH),
      .INC_STYLE (INC_STYLE)
   ) u_next (
      .op  (op),
      .cur (cnt),
      .din (din),
      .nxt (nxt)
   );

   casc_cnt_reg #(
      .WIDTH (WIDTH)
   ) u_reg (
      .clk   (clk),
      .clr_n (clr_n),
      .nxt   (nxt),
      .q     (cnt)
   );

   casc_cnt_tc #(
      .WIDTH    (WIDTH),
      .TC_STYLE (TC_STYLE),
      .TC_GROUP (TC_GROUP)
   ) u_tc (
      .cnt    (cnt),
      .en_trk (en_trk),
      .tc     (tc)
   );

   // ---------------- embedded checks ----------------

   // R3 / R4: a load captures din whatever the enables are.
   assert_load_capture_R3: assert property (
      @(posedge clk) disable iff (!clr_n)
      !ld_n |=> cnt == $past(din)
   ) else $error("load did not capture din");

   // R5: both enables high steps by one.
   assert_step_one_R5: assert property (
      @(posedge clk) disable iff (!clr_n)
      (ld_n && en_par && en_trk) |=> cnt == $past(cnt) + ONE
   ) else $error("count did not step by one");

   // R5: either enable low holds the count.
   assert_hold_R5: assert property (
      @(posedge clk) disable iff (!clr_n)
      (ld_n && !(en_par && en_trk)) |=> $stable(cnt)
   ) else $error("count moved while an enable was low");

   // R7: step from all ones gives zero.
   assert_wrap_R7: assert property (
      @(posedge clk) disable iff (!clr_n)
      (ld_n && en_par && en_trk && (&cnt)) |=> cnt == '0
   ) else $error("no wrap to zero");

   // R6: terminal count stays low while the trickle enable is low.
   assert_tc_gated_R6: assert property (
      @(posedge clk) disable iff (!clr_n)
      !en_trk |-> !tc
   ) else $error("tc high with en_trk low");

   // R2: the count is zero while clear is held.
   assert_clear_zero_R2: assert property (
      @(negedge clk)
      !clr_n |-> cnt == '0
   ) else $error("count nonzero during clear");

endmodule

// File: tb/casc_bin_counter_tb_top.sv
`timescale 1ns/1ps
module casc_bin_counter_tb_top;

   localparam int STW = 4;
   localparam int TW  = 2 * STW;

   logic          clk = 1'b0;
   logic          clr_n = 1'b0;
   logic          ld_n = 1'b1;
   logic          en_par = 1'b0;
   logic          en_trk = 1'b0;
   logic [TW-1:0] din = '0;
   logic [STW-1:0] cnt_lo, cnt_hi;
   logic          tc_lo, tc_hi;

   always #2 clk = ~clk;   // 250 MHz

   // lower stage
   casc_bin_counter #(.WIDTH(STW)) dut_i (
      .clk    (clk),
      .clr_n  (clr_n),
      .ld_n   (ld_n),
      .en_par (en_par),
      .en_trk (en_trk),
      .din    (din[STW-1:0]),
      .cnt    (cnt_lo),
      .tc     (tc_lo)
   );

   // upper stage, trickle enable from lower stage's terminal count (R8)
   casc_bin_counter #(.WIDTH(STW), .INC_STYLE(0), .TC_STYLE(0)) dut_hi_i (
      .clk    (clk),
      .clr_n  (clr_n),
      .ld_n   (ld_n),
      .en_par (en_par),
      .en_trk (tc_lo),
      .din    (din[TW-1:STW]),
      .cnt    (cnt_hi),
      .tc     (tc_hi)
   );

   wire [TW-1:0] wide_cnt = {cnt_hi, cnt_lo};

   typedef struct {
      logic [TW-1:0] exp_cnt;
      logic          exp_tc_lo;
      logic          exp_tc_hi;
      string         tag;
   } exp_item_t;

   exp_item_t     sb_q[$];
   logic [TW-1:0] model = '0;
   int            n_chk = 0;
   int            n_bad = 0;

   task automatic chk(input logic ok, input string tag,
                      input logic [TW-1:0] act, input logic [TW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // driver: apply one cycle of controls and queue the expected result
   task automatic step(input logic ld, input logic ep, input logic et,
                       input logic [TW-1:0] d, input string tag);
      exp_item_t it;
      @(negedge clk);
      ld_n = ld; en_par = ep; en_trk = et; din = d;
      if (!ld)          model = d;
      else if (ep && et) model = model + TW'(1);
      it.exp_cnt   = model;
      it.exp_tc_lo = et && (model[STW-1:0] == '1);
      it.exp_tc_hi = et && (model == '1);
      it.tag       = tag;
      sb_q.push_back(it);
   endtask

   // monitor: after each edge compare against the head of the queue
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_item_t it;
         it = sb_q.pop_front();
         chk(wide_cnt == it.exp_cnt, it.tag, wide_cnt, it.exp_cnt);
         chk(tc_lo == it.exp_tc_lo, {it.tag, " tc_lo R6"},
             TW'(tc_lo), TW'(it.exp_tc_lo));
         chk(tc_hi == it.exp_tc_hi, {it.tag, " tc_hi R8"},
             TW'(tc_hi), TW'(it.exp_tc_hi));
      end
   end

   initial begin
      #(200000 * 4);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      report();
   end

   initial begin
      // reset state (R2)
      repeat (2) @(negedge clk);
      #0.5;
      chk(wide_cnt == '0, "R2 reset count", wide_cnt, '0);
      chk(!tc_lo && !tc_hi, "R2 reset tc", TW'({tc_hi, tc_lo}), '0);
      @(negedge clk);
      clr_n = 1'b1;
      model = '0;

      // loads, with and without enables (R3, R4)
      step(0, 0, 0, 8'h3C, "R4 load enables low");
      step(0, 1, 1, 8'hA5, "R3 load enables high");
      step(0, 1, 0, 8'h17, "R4 load trickle low");

      // counting across the nibble carry (R5, R8, R1)
      for (int i = 0; i < 20; i++) step(1, 1, 1, 8'h00, "R1/R5/R8 count");

      // each enable held low alone (R5); tc gated (R6)
      step(0, 1, 1, 8'h4F, "R3 load 4F");
      for (int i = 0; i < 3; i++) step(1, 0, 1, 8'hFF, "R5 hold par low");
      for (int i = 0; i < 3; i++) step(1, 1, 0, 8'hFF, "R5 hold trk low");

      // wrap-around of the wide counter (R7, R8)
      step(0, 1, 1, 8'hFD, "R3 load FD");
      for (int i = 0; i < 4; i++) step(1, 1, 1, 8'h00, "R7/R8 wrap");

      // tc ignores parallel enable (R6)
      step(0, 0, 1, 8'hFF, "R3 load FF");
      step(1, 0, 1, 8'h00, "R6 par low tc high");
      step(1, 1, 0, 8'h00, "R6 trk low tc low");

      // tc follows en_trk without a clock edge (R6)
      @(negedge clk);
      en_par = 1'b0; en_trk = 1'b1;
      #0.5;
      chk(tc_hi == 1'b1, "R6 tc rises with en_trk", TW'(tc_hi), TW'(1));
      en_trk = 1'b0;
      #0.5;
      chk(tc_lo == 1'b0, "R6 tc drops with en_trk", TW'(tc_lo), TW'(0));

      // async clear mid-cycle with load and enables active (R2)
      step(0, 1, 1, 8'h96, "R3 load 96");
      @(negedge clk);
      #0.5;
      ld_n = 1'b0; en_par = 1'b1; en_trk = 1'b1; din = 8'h77;
      clr_n = 1'b0;
      #0.5;
      chk(wide_cnt == '0, "R2 clear mid-cycle", wide_cnt, '0);
      @(posedge clk);
      #1;
      chk(wide_cnt == '0, "R2 clear across edge", wide_cnt, '0);
      @(negedge clk);
      clr_n = 1'b1; ld_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
      model = '0;
      #0.5;
      chk(wide_cnt == '0, "R2 after release", wide_cnt, '0);

      // long run through a full wrap (R1, R5, R7, R8)
      for (int i = 0; i < 300; i++) step(1, 1, 1, 8'h00, "R1/R8 long run");

      // count stays put between edges (R1)
      @(negedge clk);
      en_par = 1'b0;
      #1.5;
      chk(wide_cnt == model, "R1 stable between edges", wide_cnt, model);

      repeat (3) @(negedge clk);
      report();
   end

endmodule